// File: doc/BRIEF.md
# Transmit DMA Address Register Bank

This block holds the host-memory pointers that a transmit DMA engine works from. There are four pointers:

- the descriptor that the next transmit packet started at, which is also where transmit status is written back once the packet has gone out;
- the next descriptor the engine will fetch;
- the host address that packet data is being read from;
- the next fragment list entry to fetch.

Software programs and inspects the pointers through a 32-bit register port with a byte offset. The DMA engine moves the pointers forward through three inputs. One input advances the data pointer by one dword after each dword read. A second input, together with two 32-bit values, loads fresh descriptor and fragment-list pointers.

The two descriptor pointers and the fragment-list pointer are always dword aligned. The data pointer is different: its two low bits hold the starting byte offset of the buffer. Only the upper 30 bits form the dword bus address and advance. When software writes the current-descriptor pointer, the same value is also copied into the first-descriptor pointer, so a new packet's status location is set in one write.

Top module: `tx_dma_addr_bank`

## Requirements
- R1: After reset every pointer output, the bus address, the byte offset and every readback value are zero.
- R2: The first-descriptor (offset 0xC0), current-descriptor (0xC4) and fragment-list (0xCC) pointers always hold zero in bits 1:0. Written bits 1:0 are dropped, and readback shows them as zero.
- R3: A software write to offset 0xC4 loads the value, with bits 1:0 cleared, into both the current-descriptor and the first-descriptor pointer on the same clock edge.
- R4: A software write to offset 0xC0 changes only the first-descriptor pointer.
- R5: Each cycle with the data step input high adds one to bits 31:2 of the data pointer (offset 0xC8), wrapping from all ones to zero. Bits 1:0 stay unchanged.
- R6: A software write to offset 0xC8 stores all 32 bits. The bus address output is bits 31:2 of the data pointer, and the byte-offset output is bits 1:0.
- R7: A cycle with the advance input high loads the current-descriptor pointer from the engine's next-descriptor value and the fragment-list pointer from its next-fragment value, both with bits 1:0 cleared. The first-descriptor pointer is left unchanged.
- R8: When software writes a pointer in the same cycle that the engine updates that pointer, the software value is stored. The engine's update still applies to the other pointers.
- R9: The read data shows the pointer selected by the read offset in the same cycle. Any other offset reads zero, and a write to any other offset changes no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| swWrEn | input | 1 | Software write strobe |
| swWrOffset | input | 8 | Byte offset of the software write |
| swWrData | input | 32 | Software write data |
| swRdOffset | input | 8 | Byte offset of the software read |
| swRdData | output | 32 | Read data for swRdOffset |
| dmaDataStep | input | 1 | Advance the data pointer by one dword |
| dmaAdvance | input | 1 | Load new descriptor and fragment pointers |
| dmaNextDesc | input | 32 | Next-descriptor address from the engine |
| dmaNextFrag | input | 32 | Next-fragment address from the engine |
| firstDescAddr | output | 32 | First-descriptor pointer |
| curDescAddr | output | 32 | Current-descriptor pointer |
| dataAddr | output | 32 | Host data pointer |
| fragAddr | output | 32 | Fragment-list pointer |
| dataBusAddr | output | 30 | Dword bus address of the data pointer |
| dataByteOff | output | 2 | Starting byte offset of the data buffer |

## Verification
The assertions check, on every cycle, the relations that hold from one clock edge to the next:
- after a write to 0xC4, the first-descriptor and current-descriptor pointers are equal;
- a data step adds one to bits 31:2 and leaves the byte offset alone;
- an advance stores the aligned engine values;
- a software write to the data pointer wins over a step in the same cycle.

Only the bench's scenarios can show the rest. This covers address decoding and readback by offset, writes to unmapped offsets being ignored, the wrap of the data pointer from all ones, and the priority case on the descriptor pointer where the fragment pointer still takes the engine's value.

// File: rtl/tx_dma_addr_pkg.sv
package tx_dma_addr_pkg;

  typedef enum logic [2:0] {
    RD_NONE  = 3'd0,
    RD_FIRST = 3'd1,
    RD_CUR   = 3'd2,
    RD_DATA  = 3'd3,
    RD_FRAG  = 3'd4
  } rdSel_e;

  // Strobes from the control to the datapath; priority is already resolved
  typedef struct packed {
    logic   wrFirst;
    logic   wrCur;
    logic   wrData;
    logic   wrFrag;
    logic   stepData;
    logic   loadCur;
    logic   loadFrag;
    rdSel_e rdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/tx_dma_addr_ctl.sv
module tx_dma_addr_ctl
  import tx_dma_addr_pkg::*;
#(
  parameter int OFF_W = 8,
  parameter logic [OFF_W-1:0] OFF_FIRST = 8'hC0,
  parameter logic [OFF_W-1:0] OFF_CUR   = 8'hC4,
  parameter logic [OFF_W-1:0] OFF_DATA  = 8'hC8,
  parameter logic [OFF_W-1:0] OFF_FRAG  = 8'hCC
) (
  input  logic             swWrEn,
  input  logic [OFF_W-1:0] swWrOffset,
  input  logic [OFF_W-1:0] swRdOffset,
  input  logic             dmaDataStep,
  input  logic             dmaAdvance,
  output ctlStrobe_t       strobe
);

  logic hitFirst, hitCur, hitData, hitFrag;

  always_comb begin
    hitFirst = swWrEn && (swWrOffset == OFF_FIRST);
    hitCur   = swWrEn && (swWrOffset == OFF_CUR);
    hitData  = swWrEn && (swWrOffset == OFF_DATA);
    hitFrag  = swWrEn && (swWrOffset == OFF_FRAG);

    strobe.wrFirst  = hitFirst;
    strobe.wrCur    = hitCur;
    strobe.wrData   = hitData;
    strobe.wrFrag   = hitFrag;
    // A software write to a pointer overrides the engine's update of that pointer
    strobe.stepData = dmaDataStep && !hitData;
    strobe.loadCur  = dmaAdvance && !hitCur;
    strobe.loadFrag = dmaAdvance && !hitFrag;

    if (swRdOffset == OFF_FIRST)     strobe.rdSel = RD_FIRST;
    else if (swRdOffset == OFF_CUR)  strobe.rdSel = RD_CUR;
    else if (swRdOffset == OFF_DATA) strobe.rdSel = RD_DATA;
    else if (swRdOffset == OFF_FRAG) strobe.rdSel = RD_FRAG;
    else                             strobe.rdSel = RD_NONE;
  end

endmodule

// File: rtl/tx_dma_addr_dp.sv
module tx_dma_addr_dp
  import tx_dma_addr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ALIGN_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [DATA_W-1:0] swWrData,
  input  logic [DATA_W-1:0] dmaNextDesc,
  input  logic [DATA_W-1:0] dmaNextFrag,
  output logic [DATA_W-1:0] firstDescAddr,
  output logic [DATA_W-1:0] curDescAddr,
  output logic [DATA_W-1:0] dataAddr,
  output logic [DATA_W-1:0] fragAddr,
  output logic [DATA_W-1:0] rdData
);

  localparam int WORD_W = DATA_W - ALIGN_W;

  // Only the dword part of the aligned pointers is stored
  logic [WORD_W-1:0]  firstQ, curQ, fragQ;
  logic [DATA_W-1:0]  dataQ;
  logic [WORD_W-1:0]  swWord;

  assign swWord = swWrData[DATA_W-1:ALIGN_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstQ <= '0;
      curQ   <= '0;
      fragQ  <= '0;
      dataQ  <= '0;
    end else begin
      if (strobe.wrFirst || strobe.wrCur) firstQ <= swWord;

      if (strobe.wrCur)        curQ <= swWord;
      else if (strobe.loadCur) curQ <= dmaNextDesc[DATA_W-1:ALIGN_W];

      if (strobe.wrFrag)        fragQ <= swWord;
      else if (strobe.loadFrag) fragQ <= dmaNextFrag[DATA_W-1:ALIGN_W];

      if (strobe.wrData)
        dataQ <= swWrData;
      else if (strobe.stepData)
        dataQ <= {dataQ[DATA_W-1:ALIGN_W] + 1'b1, dataQ[ALIGN_W-1:0]};
    end
  end

  assign firstDescAddr = {firstQ, {ALIGN_W{1'b0}}};
  assign curDescAddr   = {curQ,   {ALIGN_W{1'b0}}};
  assign fragAddr      = {fragQ,  {ALIGN_W{1'b0}}};
  assign dataAddr      = dataQ;

  always_comb begin
    unique case (strobe.rdSel)
      RD_FIRST: rdData = firstDescAddr;
      RD_CUR:   rdData = curDescAddr;
      RD_DATA:  rdData = dataAddr;
      RD_FRAG:  rdData = fragAddr;
      default:  rdData = '0;
    endcase
  end

  // R3: a write to the current descriptor leaves both descriptor pointers equal
  a_r3_first_follows_cur: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(strobe.wrCur) |-> firstDescAddr == curDescAddr);

  // R5: a step adds one dword and keeps the byte offset
  a_r5_step_dword: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(strobe.stepData) |->
      (dataAddr[DATA_W-1:ALIGN_W] == $past(dataAddr[DATA_W-1:ALIGN_W]) + 1'b1) &&
      (dataAddr[ALIGN_W-1:0] == $past(dataAddr[ALIGN_W-1:0])));

  // R7: an advance stores the aligned engine values
  a_r7_advance_load: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(strobe.loadCur) && $past(strobe.loadFrag) |->
      (curDescAddr == {$past(dmaNextDesc[DATA_W-1:ALIGN_W]), {ALIGN_W{1'b0}}}) &&
      (fragAddr == {$past(dmaNextFrag[DATA_W-1:ALIGN_W]), {ALIGN_W{1'b0}}}));

  // R8: a software data write wins over a step in the same cycle
  a_r8_sw_wins_data: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(strobe.wrData) |-> dataAddr == $past(swWrData));

  // R7: an advance with no descriptor write leaves the first descriptor alone
  a_r7_first_kept: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !$past(strobe.wrFirst) && !$past(strobe.wrCur) |->
      $stable(firstDescAddr));

endmodule

// File: rtl/tx_dma_addr_bank.sv
module tx_dma_addr_bank
  import tx_dma_addr_pkg::*;
#(
  parameter int OFF_W   = 8,
  parameter int DATA_W  = 32,
  parameter int ALIGN_W = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      swWrEn,
  input  logic [OFF_W-1:0]          swWrOffset,
  input  logic [DATA_W-1:0]         swWrData,
  input  logic [OFF_W-1:0]          swRdOffset,
  output logic [DATA_W-1:0]         swRdData,
  input  logic                      dmaDataStep,
  input  logic                      dmaAdvance,
  input  logic [DATA_W-1:0]         dmaNextDesc,
  input  logic [DATA_W-1:0]         dmaNextFrag,
  output logic [DATA_W-1:0]         firstDescAddr,
  output logic [DATA_W-1:0]         curDescAddr,
  output logic [DATA_W-1:0]         dataAddr,
  output logic [DATA_W-1:0]         fragAddr,
  output logic [DATA_W-ALIGN_W-1:0] dataBusAddr,
  output logic [ALIGN_W-1:0]        dataByteOff
);

  ctlStrobe_t strobe;

  tx_dma_addr_ctl #(.OFF_W(OFF_W)) u_ctl (
    .swWrEn      (swWrEn),
    .swWrOffset  (swWrOffset),
    .swRdOffset  (swRdOffset),
    .dmaDataStep (dmaDataStep),
    .dmaAdvance  (dmaAdvance),
    .strobe      (strobe)
  );

  tx_dma_addr_dp #(.DATA_W(DATA_W), .ALIGN_W(ALIGN_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .swWrData      (swWrData),
    .dmaNextDesc   (dmaNextDesc),
    .dmaNextFrag   (dmaNextFrag),
    .firstDescAddr (firstDescAddr),
    .curDescAddr   (curDescAddr),
    .dataAddr      (dataAddr),
    .fragAddr      (fragAddr),
    .rdData        (swRdData)
  );

  assign dataBusAddr = dataAddr[DATA_W-1:ALIGN_W];
  assign dataByteOff = dataAddr[ALIGN_W-1:0];

endmodule

// File: tb/tx_dma_addr_bank_tb.sv
module tx_dma_addr_bank_tb;

  logic        clk = 0;
  logic        rstN = 0;
  logic        swWrEn = 0;
  logic [7:0]  swWrOffset = 0;
  logic [31:0] swWrData = 0;
  logic [7:0]  swRdOffset = 0;
  logic [31:0] swRdData;
  logic        dmaDataStep = 0;
  logic        dmaAdvance = 0;
  logic [31:0] dmaNextDesc = 0;
  logic [31:0] dmaNextFrag = 0;
  logic [31:0] firstDescAddr, curDescAddr, dataAddr, fragAddr;
  logic [29:0] dataBusAddr;
  logic [1:0]  dataByteOff;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tx_dma_addr_bank u_dut (
    .clk(clk), .rstN(rstN),
    .swWrEn(swWrEn), .swWrOffset(swWrOffset), .swWrData(swWrData),
    .swRdOffset(swRdOffset), .swRdData(swRdData),
    .dmaDataStep(dmaDataStep), .dmaAdvance(dmaAdvance),
    .dmaNextDesc(dmaNextDesc), .dmaNextFrag(dmaNextFrag),
    .firstDescAddr(firstDescAddr), .curDescAddr(curDescAddr),
    .dataAddr(dataAddr), .fragAddr(fragAddr),
    .dataBusAddr(dataBusAddr), .dataByteOff(dataByteOff)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic readCheck(string req, logic [7:0] off, logic [31:0] exp);
    swRdOffset = off;
    #0.5;
    check(req, $sformatf("read 0x%h", off), swRdData, exp);
  endtask

  // Drives one write at a negedge; returns at the next negedge with the result visible
  task automatic swWrite(logic [7:0] off, logic [31:0] val);
    @(negedge clk);
    swWrEn = 1; swWrOffset = off; swWrData = val;
    @(negedge clk);
    swWrEn = 0;
  endtask

  task automatic testReset();
    check("R1", "first", firstDescAddr, 0);
    check("R1", "cur", curDescAddr, 0);
    check("R1", "data", dataAddr, 0);
    check("R1", "frag", fragAddr, 0);
    check("R1", "busAddr", {2'b0, dataBusAddr}, 0);
    check("R1", "byteOff", {30'b0, dataByteOff}, 0);
    readCheck("R1", 8'hC8, 0);
  endtask

  task automatic testCurCopies();
    swWrite(8'hC4, 32'h1234_567F);
    check("R3", "cur", curDescAddr, 32'h1234_567C);
    check("R3", "first copy", firstDescAddr, 32'h1234_567C);
    readCheck("R2", 8'hC4, 32'h1234_567C);
    readCheck("R2", 8'hC0, 32'h1234_567C);
  endtask

  task automatic testFirstOnly();
    swWrite(8'hC0, 32'hAAAA_5557);
    check("R4", "first", firstDescAddr, 32'hAAAA_5554);
    check("R4", "cur untouched", curDescAddr, 32'h1234_567C);
    check("R4", "data untouched", dataAddr, 0);
    check("R4", "frag untouched", fragAddr, 0);
  endtask

  task automatic testFragAlign();
    swWrite(8'hCC, 32'hFFFF_FFFF);
    check("R2", "frag", fragAddr, 32'hFFFF_FFFC);
    readCheck("R2", 8'hCC, 32'hFFFF_FFFC);
  endtask

  task automatic testUnmapped();
    swWrite(8'hD0, 32'hFFFF_FFFF);
    swWrite(8'hC1, 32'h0BAD_0BAD);
    check("R9", "first", firstDescAddr, 32'hAAAA_5554);
    check("R9", "cur", curDescAddr, 32'h1234_567C);
    check("R9", "data", dataAddr, 0);
    check("R9", "frag", fragAddr, 32'hFFFF_FFFC);
    readCheck("R9", 8'hD0, 0);
    readCheck("R9", 8'hC1, 0);
  endtask

  task automatic testDataStep();
    swWrite(8'hC8, 32'h0000_1003);
    check("R6", "data", dataAddr, 32'h0000_1003);
    check("R6", "busAddr", {2'b0, dataBusAddr}, 32'h0000_0400);
    check("R6", "byteOff", {30'b0, dataByteOff}, 3);
    dmaDataStep = 1;
    repeat (3) @(negedge clk);
    dmaDataStep = 0;
    check("R5", "after 3 steps", dataAddr, 32'h0000_100F);
    check("R5", "busAddr", {2'b0, dataBusAddr}, 32'h0000_0403);
    readCheck("R9", 8'hC8, 32'h0000_100F);
    swWrite(8'hC8, 32'hFFFF_FFFE);
    dmaDataStep = 1;
    @(negedge clk);
    dmaDataStep = 0;
    check("R5", "wrap", dataAddr, 32'h0000_0002);
  endtask

  task automatic testAdvance();
    @(negedge clk);
    dmaAdvance = 1; dmaNextDesc = 32'h0000_2003; dmaNextFrag = 32'h0000_3001;
    @(negedge clk);
    dmaAdvance = 0;
    check("R7", "cur", curDescAddr, 32'h0000_2000);
    check("R7", "frag", fragAddr, 32'h0000_3000);
    check("R7", "first kept", firstDescAddr, 32'hAAAA_5554);
  endtask

  task automatic testPriority();
    @(negedge clk);
    swWrEn = 1; swWrOffset = 8'hC8; swWrData = 32'h0000_0050; dmaDataStep = 1;
    @(negedge clk);
    swWrEn = 0; dmaDataStep = 0;
    check("R8", "data write beats step", dataAddr, 32'h0000_0050);
    @(negedge clk);
    swWrEn = 1; swWrOffset = 8'hC4; swWrData = 32'h0000_0100;
    dmaAdvance = 1; dmaNextDesc = 32'h0000_0200; dmaNextFrag = 32'h0000_0304;
    @(negedge clk);
    swWrEn = 0; dmaAdvance = 0;
    check("R8", "cur write beats advance", curDescAddr, 32'h0000_0100);
    check("R8", "first copy", firstDescAddr, 32'h0000_0100);
    check("R8", "frag still from engine", fragAddr, 32'h0000_0304);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testCurCopies();
    testFirstOnly();
    testFragAlign();
    testUnmapped();
    testDataStep();
    testAdvance();
    testPriority();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #40000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule